// File: doc/BRIEF.md
# Prescaled Window PWM Channel

This block is one pulse-width-modulated output with a small write-only register port. A two-stage prescaler divides the core clock into a position tick. The first stage is a linear divider. The second stage counts a power-of-two number of first-stage wraps. A position counter steps once per tick and runs from zero up to a programmed terminal value before it wraps. Two compare points, a start position and an end position, mark the window in which the output is asserted.

Software writes three registers. The control register holds the enables, the polarity bit and both divider settings. The length register holds the terminal count. The window register holds the start and end positions. The counter and divider settings are double-buffered, so a new value reaches the running logic only when a period ends. The output-enable and run-enable bits act at once. When the run enable is low, the counter is held at zero. In that state the buffered settings flow straight through, so software can configure the channel before it starts it.

Top module: `pwm_window_chan`

## Requirements
- R1: After reset the output is low, both enables and the polarity bit are cleared, and the output stays low until the channel is configured and started.
- R2: One counter position lasts Q = (L + 1) * 2^H core clocks. L is control bits [14:7] and H is control bits [6:3]. The first position after a start lasts a full Q.
- R3: The counter visits positions 0 to P and then wraps to 0, so a period is (P + 1) * Q clocks. P is bits [7:0] of the length register (select 1).
- R4: With start point S (window register bits [7:0]) and end point E (bits [15:8], select 2), the output is asserted at positions S <= pos < E when S < E. It is asserted at pos >= S or pos < E when S > E.
- R5: When S equals E, the output is asserted for the whole period.
- R6: Clearing the output enable (control bit 0) forces the idle level from the first cycle after the write, without waiting for the period to end.
- R7: Clearing the run enable (control bit 1) forces the idle level and clears the counter and prescaler. While it is clear, every register can be written. Setting it again starts at position 0 with the latest settings.
- R8: The polarity bit (control bit 2) swaps the asserted and idle levels. This includes the idle level driven while the channel is disabled.
- R9: A new window, length or divider value written while running takes effect at the first position of the next period. The current period finishes with the old values.
- R10: A write is taken on a clock edge where wr_en is high. wr_sel selects control (0), length (1) or window (2). Select 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | 16 | Write data |
| pwm_o | output | 1 | PWM output pin level |

## Verification
The main function is driven with several settings. Undivided clocks with a mid-period window check the basic compare placement. A mixed linear and power-of-two divider checks that both stages multiply. A start point above the end point checks the wrap-around window. Equal points check the full-on case. Mid-run writes to the window and the length are placed a few positions before the wrap, which separates a design that buffers its settings from one that applies them at once. Stop, reconfigure and restart sequences, plus a mid-period output-enable drop, separate immediate controls from buffered ones. An inverted run shows that the polarity also moves the idle level.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_LENGTH = 2'd1,
        SEL_WINDOW = 2'd2
    } reg_sel_e;

    localparam int unsigned CTRL_OUT_BIT = 0;
    localparam int unsigned CTRL_RUN_BIT = 1;
    localparam int unsigned CTRL_INV_BIT = 2;
    localparam int unsigned CTRL_DH_LSB  = 3;
endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs #(
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned DIVL_W = 8,
    parameter int unsigned DIVH_W = 4,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wrap_i,
    output logic              out_en_o,
    output logic              run_en_o,
    output logic              inv_o,
    output logic [DIVH_W-1:0] div_h_o,
    output logic [DIVL_W-1:0] div_l_o,
    output logic [CNT_W-1:0]  period_o,
    output logic [CNT_W-1:0]  rise_o,
    output logic [CNT_W-1:0]  fall_o
);
    import pwm_pkg::*;

    localparam int unsigned DL_LSB = CTRL_DH_LSB + DIVH_W;

    typedef struct packed {
        logic              out_en;
        logic              run_en;
        logic              inv;
        logic [DIVH_W-1:0] dh_s;
        logic [DIVL_W-1:0] dl_s;
        logic [CNT_W-1:0]  per_s;
        logic [CNT_W-1:0]  rise_s;
        logic [CNT_W-1:0]  fall_s;
        logic [DIVH_W-1:0] dh_w;
        logic [DIVL_W-1:0] dl_w;
        logic [CNT_W-1:0]  per_w;
        logic [CNT_W-1:0]  rise_w;
        logic [CNT_W-1:0]  fall_w;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_sel)
                SEL_CTRL: begin
                    st_d.out_en = wr_data[CTRL_OUT_BIT];
                    st_d.run_en = wr_data[CTRL_RUN_BIT];
                    st_d.inv    = wr_data[CTRL_INV_BIT];
                    st_d.dh_s   = wr_data[CTRL_DH_LSB +: DIVH_W];
                    st_d.dl_s   = wr_data[DL_LSB +: DIVL_W];
                end
                SEL_LENGTH: st_d.per_s = wr_data[CNT_W-1:0];
                SEL_WINDOW: begin
                    st_d.rise_s = wr_data[0 +: CNT_W];
                    st_d.fall_s = wr_data[CNT_W +: CNT_W];
                end
                default: ;
            endcase
        end
        // working copy follows the shadow at a period wrap or while stopped
        if (wrap_i || !st_q.run_en) begin
            st_d.dh_w   = st_q.dh_s;
            st_d.dl_w   = st_q.dl_s;
            st_d.per_w  = st_q.per_s;
            st_d.rise_w = st_q.rise_s;
            st_d.fall_w = st_q.fall_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_en_o = st_q.out_en;
    assign run_en_o = st_q.run_en;
    assign inv_o    = st_q.inv;
    assign div_h_o  = st_q.dh_w;
    assign div_l_o  = st_q.dl_w;
    assign period_o = st_q.per_w;
    assign rise_o   = st_q.rise_w;
    assign fall_o   = st_q.fall_w;

    AST_WORKING_HELD: assert property (@(posedge clk) disable iff (!rst_n) (st_q.run_en && !wrap_i) |=> ($stable(st_q.per_w) && $stable(st_q.rise_w) && $stable(st_q.fall_w))) else $error("working copy changed mid-period"); // R9
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int unsigned DIVL_W = 8,
    parameter int unsigned DIVH_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [DIVL_W-1:0] div_l_i,
    input  logic [DIVH_W-1:0] div_h_i,
    output logic              tick_o
);
    localparam int unsigned EXP_W = (1 << DIVH_W) - 1;

    typedef struct packed {
        logic [DIVL_W-1:0] lin;
        logic [EXP_W-1:0]  expo;
    } pre_t;

    pre_t st_d, st_q;
    logic [EXP_W-1:0] exp_mask;
    logic             lin_end;
    logic             exp_end;

    always_comb begin
        exp_mask = ~({EXP_W{1'b1}} << div_h_i);
        lin_end  = (st_q.lin == div_l_i);
        exp_end  = (st_q.expo == exp_mask);
        tick_o   = run_i && lin_end && exp_end;
        st_d     = st_q;
        if (!run_i) begin
            st_d = '0;
        end else if (lin_end) begin
            st_d.lin  = '0;
            st_d.expo = exp_end ? '0 : st_q.expo + 1'b1;
        end else begin
            st_d.lin = st_q.lin + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_LIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) run_i |-> (st_q.lin <= div_l_i)) else $error("linear stage out of range"); // R2
    AST_EXP_RANGE: assert property (@(posedge clk) disable iff (!rst_n) run_i |-> (st_q.expo <= exp_mask)) else $error("power stage out of range"); // R2
endmodule

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] rise_i,
    input  logic [CNT_W-1:0] fall_i,
    output logic             wrap_o,
    output logic             active_o
);
    typedef struct packed {
        logic [CNT_W-1:0] pos;
    } pos_t;

    pos_t st_d, st_q;

    always_comb begin
        wrap_o = tick_i && (st_q.pos == period_i);
        st_d   = st_q;
        if (!run_i)      st_d.pos = '0;
        else if (wrap_o) st_d.pos = '0;
        else if (tick_i) st_d.pos = st_q.pos + 1'b1;

        if (rise_i == fall_i)     active_o = 1'b1;
        else if (rise_i < fall_i) active_o = (st_q.pos >= rise_i) && (st_q.pos < fall_i);
        else                      active_o = (st_q.pos >= rise_i) || (st_q.pos < fall_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n) run_i |-> (st_q.pos <= period_i)) else $error("position beyond terminal"); // R3
    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) !run_i |=> (st_q.pos == '0)) else $error("counter not cleared when stopped"); // R7
endmodule

// File: rtl/pwm_window_chan.sv
module pwm_window_chan #(
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned DIVL_W = 8,
    parameter int unsigned DIVH_W = 4,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pwm_o
);
    logic              out_en, run_en, inv, tick, wrap, active;
    logic [DIVH_W-1:0] div_h;
    logic [DIVL_W-1:0] div_l;
    logic [CNT_W-1:0]  period, rise, fall;

    pwm_cfg_regs #(.CNT_W(CNT_W), .DIVL_W(DIVL_W), .DIVH_W(DIVH_W), .DATA_W(DATA_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .wrap_i(wrap), .out_en_o(out_en), .run_en_o(run_en), .inv_o(inv),
        .div_h_o(div_h), .div_l_o(div_l), .period_o(period), .rise_o(rise), .fall_o(fall)
    );

    pwm_prescaler #(.DIVL_W(DIVL_W), .DIVH_W(DIVH_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run_i(run_en), .div_l_i(div_l), .div_h_i(div_h), .tick_o(tick)
    );

    pwm_edge_gen #(.CNT_W(CNT_W)) u_edge (
        .clk(clk), .rst_n(rst_n), .run_i(run_en), .tick_i(tick),
        .period_i(period), .rise_i(rise), .fall_i(fall), .wrap_o(wrap), .active_o(active)
    );

    assign pwm_o = (out_en && run_en && active) ^ inv;

    AST_WRAP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) wrap |-> tick) else $error("wrap without tick"); // R3
    AST_STOP_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n) !run_en |-> !tick) else $error("tick while stopped"); // R7
endmodule

// File: tb/sim_pwm_window_chan.sv
module sim_pwm_window_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        pwm_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int dl; int dh; int per; int rise; int fall;
    } cfg_t;

    pwm_window_chan u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
                        .wr_data(wr_data), .pwm_o(pwm_o));

    always #5 clk = ~clk;

    function automatic bit in_window(int pos, cfg_t c);
        if (c.rise == c.fall) return 1'b1;
        if (c.rise < c.fall)  return (pos >= c.rise) && (pos < c.fall);
        return (pos >= c.rise) || (pos < c.fall);
    endfunction

    function automatic logic [15:0] ctrl_word(bit oe, bit run, bit iv, cfg_t c);
        return 16'((c.dl << 7) | (c.dh << 3) | (int'(iv) << 2) | (int'(run) << 1) | int'(oe));
    endfunction

    task automatic reg_write(logic [1:0] sel, logic [15:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic check(bit ok, string req, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // stopped configure, then start; first sample after return is position 0
    task automatic start_chan(cfg_t c, bit iv);
        reg_write(2'd0, ctrl_word(1'b1, 1'b0, iv, c));
        reg_write(2'd1, 16'(c.per));
        reg_write(2'd2, 16'((c.fall << 8) | c.rise));
        reg_write(2'd0, ctrl_word(1'b1, 1'b1, iv, c));
    endtask

    // compare n cycles against settings a, switching to b after a's first period;
    // optional write at sample wr_at; output idle from sample kill_at
    task automatic window(string req, int n, cfg_t a, cfg_t b, bit iv,
                          int wr_at, logic [1:0] sel, logic [15:0] data, int kill_at);
        int bad = 0; int bad_t = -1; int bad_a = 0; int bad_e = 0;
        int qa = (a.dl + 1) << a.dh;
        int qb = (b.dl + 1) << b.dh;
        int first_len = qa * (a.per + 1);
        for (int t = 0; t < n; t++) begin
            bit e;
            @(negedge clk);
            if (t < first_len) e = in_window(t / qa, a);
            else e = in_window(((t - first_len) / qb) % (b.per + 1), b);
            if (kill_at >= 0 && t >= kill_at) e = 1'b0;
            e = e ^ iv;
            if (pwm_o !== e) begin
                if (bad == 0) begin bad_t = t; bad_a = int'(pwm_o); bad_e = int'(e); end
                bad++;
            end
            if (t == wr_at) begin wr_en = 1'b1; wr_sel = sel; wr_data = data; end
            if (t == wr_at + 1) wr_en = 1'b0;
        end
        wr_en = 1'b0;
        if (bad != 0) $display("  first mismatch at sample %0d (%s)", bad_t, req);
        check(bad == 0, req, bad_a, bad_e);
    endtask

    task automatic t_reset();
        check(pwm_o === 1'b0, "R1 reset level", int'(pwm_o), 0);
        repeat (20) @(negedge clk);
        check(pwm_o === 1'b0, "R1 idle after reset", int'(pwm_o), 0);
    endtask

    task automatic t_basic();
        cfg_t c = '{0, 0, 9, 2, 6};
        start_chan(c, 1'b0);
        window("R4 basic window, R3 length", 40, c, c, 1'b0, -1, 2'd0, 16'd0, -1);
    endtask

    task automatic t_divider();
        cfg_t c = '{2, 1, 4, 1, 3};
        start_chan(c, 1'b0);
        window("R2 two-stage divider, R10 ctrl fields", 90, c, c, 1'b0, -1, 2'd0, 16'd0, -1);
    endtask

    task automatic t_divider_pow();
        cfg_t c = '{0, 3, 3, 0, 2};
        start_chan(c, 1'b0);
        window("R2 power stage only", 96, c, c, 1'b0, -1, 2'd0, 16'd0, -1);
    endtask

    task automatic t_wrapwin();
        cfg_t c = '{1, 0, 7, 6, 2};
        start_chan(c, 1'b0);
        window("R4 wrapped window", 64, c, c, 1'b0, -1, 2'd0, 16'd0, -1);
    endtask

    task automatic t_full();
        cfg_t c = '{0, 0, 5, 3, 3};
        cfg_t z = '{0, 0, 5, 0, 0};
        start_chan(c, 1'b0);
        window("R5 equal points mid", 24, c, c, 1'b0, -1, 2'd0, 16'd0, -1);
        start_chan(z, 1'b0);
        window("R5 equal points zero", 24, z, z, 1'b0, -1, 2'd0, 16'd0, -1);
    endtask

    task automatic t_invert();
        cfg_t c = '{0, 1, 5, 1, 4};
        reg_write(2'd0, ctrl_word(1'b1, 1'b0, 1'b1, c));
        @(negedge clk);
        check(pwm_o === 1'b1, "R8 idle level inverted", int'(pwm_o), 1);
        start_chan(c, 1'b1);
        window("R8 inverted run", 48, c, c, 1'b1, -1, 2'd0, 16'd0, -1);
    endtask

    task automatic t_duty_change();
        cfg_t a = '{0, 0, 9, 2, 6};
        cfg_t b = '{0, 0, 9, 1, 8};
        start_chan(a, 1'b0);
        window("R9 window change at boundary", 40, a, b, 1'b0, 3, 2'd2, 16'((8 << 8) | 1), -1);
    endtask

    task automatic t_period_change();
        cfg_t a = '{0, 0, 9, 2, 6};
        cfg_t b = '{0, 0, 4, 2, 6};
        start_chan(a, 1'b0);
        window("R9 length change at boundary", 40, a, b, 1'b0, 2, 2'd1, 16'd4, -1);
    endtask

    task automatic t_ignored_sel();
        cfg_t a = '{0, 0, 7, 1, 5};
        start_chan(a, 1'b0);
        window("R10 select 3 ignored", 32, a, a, 1'b0, 4, 2'd3, 16'hFFFF, -1);
    endtask

    task automatic t_out_off();
        cfg_t a = '{0, 0, 9, 0, 9};
        start_chan(a, 1'b0);
        window("R6 output disable immediate", 20, a, a, 1'b0, 4, 2'd0, ctrl_word(1'b0, 1'b1, 1'b0, a), 5);
    endtask

    task automatic t_stop_restart();
        cfg_t a = '{1, 0, 9, 0, 8};
        cfg_t b = '{0, 1, 6, 2, 5};
        bit stayed_low = 1'b1;
        start_chan(a, 1'b0);
        repeat (7) @(negedge clk);
        reg_write(2'd0, ctrl_word(1'b1, 1'b0, 1'b0, a));
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (pwm_o !== 1'b0) stayed_low = 1'b0;
        end
        check(stayed_low, "R7 idle while stopped", int'(pwm_o), 0);
        start_chan(b, 1'b0);
        window("R7 restart from zero with new settings", 56, b, b, 1'b0, -1, 2'd0, 16'd0, -1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_divider();
        t_divider_pow();
        t_wrapwin();
        t_full();
        t_invert();
        t_duty_change();
        t_period_change();
        t_ignored_sel();
        t_out_off();
        t_stop_restart();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule